// File: doc/BRIEF.md
# Infrared Mid-Rate Receive Frame Checker

This block sits behind the flag detector and bit unstuffer of an infrared mid-rate receiver. It sees one frame at a time as a serial stream of de-stuffed bits. Strobes from upstream open and close each frame. The first eight bits of each frame are the station address and arrive least-significant bit first. The last sixteen bits are the frame check value and arrive most-significant bit first. Every bit in between is payload.

A sixteen-bit delay line holds back the newest bits. Only bits that cannot belong to the check field reach the CRC engine and the byte assembler. When the frame closes, the delay line holds the expected check value. The address byte decides whether the frame is accepted. An accepted frame's bytes, address byte included, go out on a byte stream. The last byte carries an end-of-frame tag. A one-cycle completion pulse carries the frame status, and a CRC mismatch also raises an interrupt pulse.

Top module: `mir_rx_frame_chk`

## Requirements
- R1: Payload bytes, the address byte first, are assembled least-significant bit first from all bits except the final sixteen. They are emitted in arrival order with no decoding.
- R2: With the filter enabled, a frame is accepted when its first byte equals `stn_addr_i` or the broadcast value 0xFF, and is rejected otherwise.
- R3: With `filt_en_i` low, every frame of at least 24 whole-byte bits is accepted, whatever its first byte.
- R4: A rejected frame emits no byte beats and raises no interrupt. Its completion pulse has `sts_addr_miss_o` high.
- R5: The CRC is preset to 0xFFFF at frame start. It uses polynomial 0x1021 (x^16+x^12+x^5+1). Bits enter it in arrival order, shifted in at the top with feedback from bit 15. It covers all bits but the last sixteen, and those sixteen are taken MSB first as the expected value. A mismatch on an accepted, well-formed frame sets `sts_crc_err_o` and pulses `crc_irq_o` in the completion cycle.
- R6: If the bits before the check field are not a whole number of bytes, the completion status is abort. The last complete accepted byte still goes out with the end-of-frame tag.
- R7: A frame of fewer than 24 bits completes with abort status.
- R8: `frm_done_o` pulses exactly once, one cycle after an end strobe that closes an open frame. The status outputs and `crc_irq_o` are low outside that pulse. At most one status is set, with priority abort, then address miss, then CRC error.
- R9: Within a frame, every emitted byte except the last has `byte_eof_o` low. The last one has it high and appears in the same cycle as `frm_done_o`.
- R10: A bit valid in the same cycle as a start or end strobe is discarded. A start strobe while a frame is open restarts the frame without completing it. An end strobe with no open frame has no effect.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_start_i | input | 1 | Opens a frame (strobe) |
| frm_end_i | input | 1 | Closes the open frame (strobe) |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | De-stuffed serial data bit |
| filt_en_i | input | 1 | Enables address filtering |
| stn_addr_i | input | 8 | Programmed station address |
| byte_vld_o | output | 1 | Byte beat valid |
| byte_o | output | 8 | Received byte |
| byte_eof_o | output | 1 | Marks the last byte of a frame |
| frm_done_o | output | 1 | Frame completion pulse, qualifies status |
| sts_abort_o | output | 1 | Short frame or partial byte |
| sts_addr_miss_o | output | 1 | Address filter rejected the frame |
| sts_crc_err_o | output | 1 | Check value mismatch |
| crc_irq_o | output | 1 | CRC error interrupt pulse |

## Verification
The address filter is swept over all 256 first-byte values against a fixed station address, which separates exact matches, broadcast and misses. A reduced sweep with the filter disabled shows that the address no longer matters. A single-bit error is placed in each of the sixteen check bits in turn, and good frames of one to eight bytes are sent with varied contents. Together these show whether the CRC, its bit order and its coverage are right. Partial-byte and very short frames exercise the two abort paths. Strobe collisions, a restart mid-frame and an end strobe while idle exercise the framing rules. Idle cycles are inserted between bits throughout to show that only qualified bits count.

// File: rtl/mir_rx_pkg.sv
package mir_rx_pkg;

    localparam int unsigned CHK_W  = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [CHK_W-1:0]  CRC_POLY   = 16'h1021;
    localparam logic [CHK_W-1:0]  CRC_INIT   = 16'hFFFF;
    localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF;

    // completion status, at most one field set
    typedef struct packed {
        logic abort;
        logic addr_miss;
        logic crc_err;
    } frm_sts_t;

endpackage

// File: rtl/mir_rx_dly_line.sv
module mir_rx_dly_line #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] line_o,
    output logic         full_o
);

    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    typedef struct packed {
        logic [W-1:0]     line;
        logic [CNT_W-1:0] cnt;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (clr_i) begin
            dly_d.line = '0;
            dly_d.cnt  = '0;
        end else if (shift_i) begin
            dly_d.line = {dly_q.line[W-2:0], bit_i};
            if (dly_q.cnt != CNT_FULL) begin
                dly_d.cnt = dly_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    assign line_o = dly_q.line;
    assign full_o = (dly_q.cnt == CNT_FULL);

endmodule

// File: rtl/mir_rx_crc_step.sv
module mir_rx_crc_step #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    logic fb;
    assign fb = crc_i[W-1] ^ bit_i;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_low
            assign crc_o[i] = fb & POLY[i];
        end else begin : g_up
            assign crc_o[i] = crc_i[i-1] ^ (fb & POLY[i]);
        end
    end

endmodule

// File: rtl/mir_rx_addr_cmp.sv
module mir_rx_addr_cmp #(
    parameter int unsigned  W     = 8,
    parameter logic [W-1:0] BCAST = 8'hFF
) (
    input  logic [W-1:0] byte_i,
    input  logic [W-1:0] stn_i,
    input  logic         en_i,
    output logic         hit_o
);

    assign hit_o = !en_i || (byte_i == stn_i) || (byte_i == BCAST);

endmodule

// File: rtl/mir_rx_frame_chk.sv
module mir_rx_frame_chk
    import mir_rx_pkg::*;
#(
    parameter int unsigned        CHK_W      = mir_rx_pkg::CHK_W,
    parameter int unsigned        BYTE_W     = mir_rx_pkg::BYTE_W,
    parameter logic [CHK_W-1:0]   CRC_POLY   = mir_rx_pkg::CRC_POLY,
    parameter logic [CHK_W-1:0]   CRC_INIT   = mir_rx_pkg::CRC_INIT,
    parameter logic [BYTE_W-1:0]  BCAST_ADDR = mir_rx_pkg::BCAST_ADDR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frm_start_i,
    input  logic              frm_end_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              filt_en_i,
    input  logic [BYTE_W-1:0] stn_addr_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_eof_o,
    output logic              frm_done_o,
    output logic              sts_abort_o,
    output logic              sts_addr_miss_o,
    output logic              sts_crc_err_o,
    output logic              crc_irq_o
);

    localparam int unsigned BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

    typedef struct packed {
        logic              active;
        logic [CHK_W-1:0]  crc;
        logic [BYTE_W-2:0] sh;
        logic [BC_W-1:0]   bc;
        logic              addr_seen;
        logic              match;
        logic              pend_vld;
        logic [BYTE_W-1:0] pend;
        logic              out_vld;
        logic [BYTE_W-1:0] out_byte;
        logic              out_eof;
        logic              done;
        frm_sts_t          sts;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    logic              take_bit;
    logic [CHK_W-1:0]  line;
    logic              line_full;
    logic              exit_bit;
    logic [CHK_W-1:0]  crc_nxt;
    logic [BYTE_W-1:0] asm_byte;
    logic              addr_hit;

    // a bit counts only inside a frame and never alongside a strobe
    assign take_bit = bit_vld_i && st_q.active && !frm_start_i && !frm_end_i;
    assign exit_bit = line[CHK_W-1];
    assign asm_byte = {exit_bit, st_q.sh};

    mir_rx_dly_line #(
        .W (CHK_W)
    ) u_dly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (frm_start_i),
        .shift_i (take_bit),
        .bit_i   (bit_i),
        .line_o  (line),
        .full_o  (line_full)
    );

    mir_rx_crc_step #(
        .W    (CHK_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_i (st_q.crc),
        .bit_i (exit_bit),
        .crc_o (crc_nxt)
    );

    mir_rx_addr_cmp #(
        .W     (BYTE_W),
        .BCAST (BCAST_ADDR)
    ) u_cmp (
        .byte_i (asm_byte),
        .stn_i  (stn_addr_i),
        .en_i   (filt_en_i),
        .hit_o  (addr_hit)
    );

    always_comb begin
        logic ab;
        logic ms;
        logic ce;
        logic keep;

        st_d         = st_q;
        st_d.out_vld = 1'b0;
        st_d.out_eof = 1'b0;
        st_d.done    = 1'b0;
        st_d.sts     = '0;
        st_d.irq     = 1'b0;
        ab           = 1'b0;
        ms           = 1'b0;
        ce           = 1'b0;
        keep         = 1'b0;

        if (frm_start_i) begin
            st_d.active    = 1'b1;
            st_d.crc       = CRC_INIT;
            st_d.sh        = '0;
            st_d.bc        = '0;
            st_d.addr_seen = 1'b0;
            st_d.match     = 1'b0;
            st_d.pend_vld  = 1'b0;
        end else if (frm_end_i && st_q.active) begin
            // no address byte means fewer than CHK_W+BYTE_W bits
            ab = !st_q.addr_seen || (st_q.bc != '0);
            ms = !ab && !st_q.match;
            ce = !ab && !ms && (st_q.crc != line);

            st_d.active        = 1'b0;
            st_d.done          = 1'b1;
            st_d.sts.abort     = ab;
            st_d.sts.addr_miss = ms;
            st_d.sts.crc_err   = ce;
            st_d.irq           = ce;
            if (st_q.pend_vld) begin
                st_d.out_vld  = 1'b1;
                st_d.out_byte = st_q.pend;
                st_d.out_eof  = 1'b1;
                st_d.pend_vld = 1'b0;
            end
        end else if (take_bit && line_full) begin
            st_d.crc = crc_nxt;
            st_d.sh  = asm_byte[BYTE_W-1:1];
            if (st_q.bc == BC_LAST) begin
                st_d.bc = '0;
                keep    = st_q.addr_seen ? st_q.match : addr_hit;
                if (!st_q.addr_seen) begin
                    st_d.addr_seen = 1'b1;
                    st_d.match     = addr_hit;
                end
                if (keep) begin
                    // hold one byte back so the last one can carry the tag
                    if (st_q.pend_vld) begin
                        st_d.out_vld  = 1'b1;
                        st_d.out_byte = st_q.pend;
                    end
                    st_d.pend     = asm_byte;
                    st_d.pend_vld = 1'b1;
                end
            end else begin
                st_d.bc = st_q.bc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld_o      = st_q.out_vld;
    assign byte_o          = st_q.out_byte;
    assign byte_eof_o      = st_q.out_eof;
    assign frm_done_o      = st_q.done;
    assign sts_abort_o     = st_q.sts.abort;
    assign sts_addr_miss_o = st_q.sts.addr_miss;
    assign sts_crc_err_o   = st_q.sts.crc_err;
    assign crc_irq_o       = st_q.irq;

endmodule

// File: rtl/mir_rx_frame_chk_sva.sv
module mir_rx_frame_chk_sva #(
    parameter int unsigned CHK_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              frm_start_i,
    input logic              frm_end_i,
    input logic              bit_vld_i,
    input logic              bit_i,
    input logic              filt_en_i,
    input logic [BYTE_W-1:0] stn_addr_i,
    input logic              byte_vld_o,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_eof_o,
    input logic              frm_done_o,
    input logic              sts_abort_o,
    input logic              sts_addr_miss_o,
    input logic              sts_crc_err_o,
    input logic              crc_irq_o
);

    localparam int unsigned LIM   = CHK_W + BYTE_W;
    localparam int unsigned CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIM);

    logic             open_q;
    logic [CNT_W-1:0] bits_q;
    logic             short_q;
    logic             beat_q;
    logic             close_ev;

    assign close_ev = frm_end_i && open_q && !frm_start_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            open_q  <= 1'b0;
            bits_q  <= '0;
            short_q <= 1'b0;
            beat_q  <= 1'b0;
        end else begin
            if (frm_start_i) begin
                open_q <= 1'b1;
                bits_q <= '0;
                beat_q <= 1'b0;
            end else begin
                if (close_ev) begin
                    open_q  <= 1'b0;
                    short_q <= (bits_q < CNT_LIM);
                end else if (bit_vld_i && open_q && bits_q != CNT_LIM) begin
                    bits_q <= bits_q + 1'b1;
                end
                if (byte_vld_o) begin
                    beat_q <= 1'b1;
                end
            end
        end
    end

    AST_EOF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_eof_o |-> (frm_done_o && byte_vld_o)); // R9

    AST_DONE_FOLLOWS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        close_ev |=> frm_done_o); // R8

    AST_NO_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frm_done_o |-> $past(close_ev)); // R10

    AST_STS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({sts_abort_o, sts_addr_miss_o, sts_crc_err_o})); // R8

    AST_STS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frm_done_o |-> !(sts_abort_o || sts_addr_miss_o || sts_crc_err_o || crc_irq_o)); // R8

    AST_IRQ_ON_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_irq_o |-> (frm_done_o && sts_crc_err_o)); // R5

    AST_MISS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_done_o && sts_addr_miss_o) |-> (!beat_q && !byte_vld_o && !crc_irq_o)); // R4

    AST_SHORT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_done_o && short_q) |-> sts_abort_o); // R7

endmodule

bind mir_rx_frame_chk mir_rx_frame_chk_sva #(
    .CHK_W  (CHK_W),
    .BYTE_W (BYTE_W)
) u_sva (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .frm_start_i     (frm_start_i),
    .frm_end_i       (frm_end_i),
    .bit_vld_i       (bit_vld_i),
    .bit_i           (bit_i),
    .filt_en_i       (filt_en_i),
    .stn_addr_i      (stn_addr_i),
    .byte_vld_o      (byte_vld_o),
    .byte_o          (byte_o),
    .byte_eof_o      (byte_eof_o),
    .frm_done_o      (frm_done_o),
    .sts_abort_o     (sts_abort_o),
    .sts_addr_miss_o (sts_addr_miss_o),
    .sts_crc_err_o   (sts_crc_err_o),
    .crc_irq_o       (crc_irq_o)
);

// File: tb/tb_mir_rx_frame_chk.sv
`timescale 1ns/100ps
module tb_mir_rx_frame_chk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       frm_end = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_d = 1'b0;
    logic       filt_en = 1'b1;
    logic [7:0] stn_addr = 8'h00;
    logic       byte_vld_o;
    logic [7:0] byte_o;
    logic       byte_eof_o;
    logic       frm_done_o;
    logic       sts_abort_o;
    logic       sts_addr_miss_o;
    logic       sts_crc_err_o;
    logic       crc_irq_o;

    always #2.5 clk = ~clk;

    mir_rx_frame_chk dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .frm_start_i     (frm_start),
        .frm_end_i       (frm_end),
        .bit_vld_i       (bit_vld),
        .bit_i           (bit_d),
        .filt_en_i       (filt_en),
        .stn_addr_i      (stn_addr),
        .byte_vld_o      (byte_vld_o),
        .byte_o          (byte_o),
        .byte_eof_o      (byte_eof_o),
        .frm_done_o      (frm_done_o),
        .sts_abort_o     (sts_abort_o),
        .sts_addr_miss_o (sts_addr_miss_o),
        .sts_crc_err_o   (sts_crc_err_o),
        .crc_irq_o       (crc_irq_o)
    );

    int n_run = 0;
    int n_fail = 0;

    logic [7:0] tx_b [0:7];
    logic [7:0] rx_b [0:15];
    logic       rx_eof [0:15];
    int         rx_n, done_n, irq_n;
    logic       got_ab, got_ms, got_ce;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        rx_n = 0; done_n = 0; irq_n = 0;
        got_ab = 1'b0; got_ms = 1'b0; got_ce = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld_o) begin
                if (rx_n < 16) begin
                    rx_b[rx_n]   = byte_o;
                    rx_eof[rx_n] = byte_eof_o;
                end
                rx_n++;
            end
            if (frm_done_o) begin
                done_n++;
                got_ab = sts_abort_o;
                got_ms = sts_addr_miss_o;
                got_ce = sts_crc_err_o;
            end
            if (crc_irq_o) irq_n++;
        end
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // mode: 0 plain, 1 bit with start, 2 bit with end, 3 restart mid-frame
    task automatic run_frame(input int nb, input int extra, input logic [7:0] xbits,
                             input logic [15:0] flip, input logic en,
                             input logic [7:0] stn, input int mode, input string req);
        logic q[$];
        logic [15:0] c;
        logic [15:0] chk;
        logic exp_ab, exp_match, exp_ms, exp_ce;
        int   exp_beats;
        q = {};
        c = 16'hFFFF;
        for (int k = 0; k < nb; k++)
            for (int j = 0; j < 8; j++) q.push_back(tx_b[k][j]);
        for (int j = 0; j < extra; j++) q.push_back(xbits[j]);
        foreach (q[i]) c = crc_upd(c, q[i]);
        chk = c ^ flip;
        for (int j = 15; j >= 0; j--) q.push_back(chk[j]);

        @(negedge clk);
        filt_en = en; stn_addr = stn;
        mon_clear();
        if (mode == 3) begin
            @(negedge clk) frm_start = 1'b1;
            @(negedge clk) frm_start = 1'b0;
            for (int i = 0; i < 13; i++) begin
                @(negedge clk) bit_vld = 1'b1; bit_d = i[0];
            end
        end
        @(negedge clk);
        frm_start = 1'b1; bit_vld = (mode == 1); bit_d = 1'b1;
        @(negedge clk);
        frm_start = 1'b0; bit_vld = 1'b0;
        foreach (q[i]) begin
            if (i % 7 == 4) begin
                @(negedge clk) bit_vld = 1'b0;
            end
            @(negedge clk) bit_vld = 1'b1; bit_d = q[i];
        end
        @(negedge clk);
        frm_end = 1'b1; bit_vld = (mode == 2); bit_d = 1'b1;
        @(negedge clk);
        frm_end = 1'b0; bit_vld = 1'b0;
        repeat (3) @(negedge clk);

        exp_ab    = (nb == 0) || (extra != 0);
        exp_match = (nb >= 1) && (!en || tx_b[0] == stn || tx_b[0] == 8'hFF);
        exp_ms    = !exp_ab && !exp_match;
        exp_ce    = !exp_ab && !exp_ms && (flip != 16'h0);
        exp_beats = exp_match ? nb : 0;

        check(rx_n == exp_beats, req, "byte beats", rx_n, exp_beats);
        for (int k = 0; k < exp_beats && k < rx_n; k++) begin
            check(rx_b[k] == tx_b[k], "R1", "byte value", int'(rx_b[k]), int'(tx_b[k]));
            check(rx_eof[k] == (k == exp_beats - 1), "R9", "eof tag",
                  int'(rx_eof[k]), int'(k == exp_beats - 1));
        end
        check(done_n == 1, "R8", "done pulses", done_n, 1);
        check(got_ab == exp_ab, req, "abort", int'(got_ab), int'(exp_ab));
        check(got_ms == exp_ms, req, "addr miss", int'(got_ms), int'(exp_ms));
        check(got_ce == exp_ce, req, "crc err", int'(got_ce), int'(exp_ce));
        check(irq_n == int'(exp_ce), req, "irq pulses", irq_n, int'(exp_ce));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        // R11: reset state
        check({byte_vld_o, byte_eof_o, frm_done_o, sts_abort_o, sts_addr_miss_o,
               sts_crc_err_o, crc_irq_o, byte_o} == '0, "R11", "outputs in reset",
              int'(byte_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({byte_vld_o, frm_done_o, crc_irq_o} == '0, "R11", "outputs after reset", 0, 0);

        // R2: every first-byte value against a fixed station address
        for (int a = 0; a < 256; a++) begin
            tx_b[0] = 8'(a); tx_b[1] = 8'(a) ^ 8'h3C;
            run_frame(2, 0, 8'h00, 16'h0, 1'b1, 8'h5A, 0, "R2");
        end
        // R3: filter disabled
        for (int a = 0; a < 256; a += 37) begin
            tx_b[0] = 8'(a); tx_b[1] = 8'hC3;
            run_frame(2, 0, 8'h00, 16'h0, 1'b0, 8'h5A, 0, "R3");
        end
        // R4: explicit miss with long payload
        for (int k = 0; k < 8; k++) tx_b[k] = 8'(k * 29 + 7);
        tx_b[0] = 8'h12;
        run_frame(6, 0, 8'h00, 16'h0, 1'b1, 8'h34, 0, "R4");
        // R5: single-bit error in each check position, and a good frame
        for (int b = 0; b < 16; b++) begin
            tx_b[0] = 8'hA7; tx_b[1] = 8'(b * 17); tx_b[2] = 8'h0F;
            run_frame(3, 0, 8'h00, 16'(1) << b, 1'b1, 8'hA7, 0, "R5");
        end
        run_frame(3, 0, 8'h00, 16'h0, 1'b1, 8'hA7, 0, "R5");
        // R1: lengths one to eight bytes, varied content
        for (int n = 1; n <= 8; n++) begin
            for (int k = 0; k < 8; k++) tx_b[k] = 8'(k * 53 + n * 11 + 1);
            tx_b[0] = 8'hFF;
            run_frame(n, 0, 8'h00, 16'h0, 1'b1, 8'h00, 0, "R1");
        end
        // R6: partial trailing byte
        for (int n = 1; n <= 3; n++) begin
            for (int x = 1; x < 8; x++) begin
                tx_b[0] = 8'h66; tx_b[1] = 8'(x); tx_b[2] = 8'h99;
                run_frame(n, x, 8'(x * 37), 16'h0, 1'b1, 8'h66, 0, "R6");
            end
        end
        // R7: frames under 24 bits
        for (int x = 0; x < 8; x++)
            run_frame(0, x, 8'hB5, 16'h0, 1'b1, 8'h00, 0, "R7");
        // R10: strobe collisions and restart
        tx_b[0] = 8'h5A; tx_b[1] = 8'h81; tx_b[2] = 8'h7E;
        run_frame(3, 0, 8'h00, 16'h0, 1'b1, 8'h5A, 1, "R10");
        run_frame(3, 0, 8'h00, 16'h0, 1'b1, 8'h5A, 2, "R10");
        run_frame(3, 0, 8'h00, 16'h0, 1'b1, 8'h5A, 3, "R10");
        // R10: end strobe while idle
        mon_clear();
        @(negedge clk) frm_end = 1'b1;
        @(negedge clk) frm_end = 1'b0;
        repeat (3) @(negedge clk);
        check(done_n == 0 && rx_n == 0, "R10", "idle end strobe done", done_n, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule